// File: doc/BRIEF.md
# Equivalent-Time Sampling Sequencer

This block times the capture of a repetitive waveform in equivalent time. It drives a stimulus pulse with a fixed period and fixed high time. It also drives a sampling strobe whose period is one clock longer than the stimulus period. Because of that difference, each strobe lands one clock later in the stimulus cycle than the one before it. Every strobe during an acquisition becomes a trigger to an external converter. Each result the converter returns is stored at the next address of a small record. When the record is full the sequencer stops and holds a done flag, and software or the next stage reads the record through a combinational read port.

A controller with three states owns the sequence. In `ST_IDLE` it waits, with all timing outputs low. A start moves it to `ST_ACQ` (transition *launch*). There both counters count from zero, triggers are issued and results are written. A start seen while in `ST_ACQ` restarts the acquisition from zero (transition *restart*). The write that fills the last record address moves it to `ST_DONE` (transition *complete*), and a start has priority over that write. In `ST_DONE` the counters are frozen and the done flag is high. A start returns it to `ST_ACQ` (transition *rearm*).

With the default sizes, the stimulus is high for 8 of every 32 clocks, the strobe repeats every 33 clocks, and 32 results of 8 bits make one record. Sample n is therefore taken n clocks into a stimulus period, so the record spans one full stimulus period at one-clock resolution. The waveform must stay periodic and stable for the whole acquisition.

Top module: `equiv_strobe_gen`

## Requirements
- R1: While reset is held, and after it is released until the first start, stim_pulse, stim_tc, strobe, adc_trig and done are all low.
- R2: Counting the first clock after a start as acquisition clock t=0, stim_pulse is high exactly when (t mod 32) < 8, while acquiring.
- R3: stim_tc is high for one clock, when (t mod 32) = 31, while acquiring.
- R4: strobe is high exactly when (t mod 33) = 0, while acquiring, so the first strobe falls at t=0.
- R5: adc_trig is high only together with strobe, and at most 32 times per acquisition. Trigger number n (counting from 0) falls at a stimulus phase (t mod 32) equal to n.
- R6: Each adc_valid seen while acquiring stores adc_data at the next record address, starting from address 0. rd_data shows the entry at rd_addr in the same cycle.
- R7: On the clock after the 32nd stored result, done goes high. From then on stim_pulse, stim_tc, strobe and adc_trig stay low until the next start.
- R8: A start in any state, including during an acquisition, clears done, restarts t at 0 on the next clock and restarts writes at address 0.
- R9: adc_valid outside an acquisition leaves the record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart an acquisition |
| adc_data | input | 8 | Converter result |
| adc_valid | input | 1 | Converter result valid for one clock |
| rd_addr | input | 5 | Record read address |
| stim_pulse | output | 1 | Stimulus pulse to the device under test |
| stim_tc | output | 1 | Last clock of each stimulus period |
| strobe | output | 1 | Sampling strobe |
| adc_trig | output | 1 | Converter trigger |
| done | output | 1 | Record complete |
| rd_data | output | 8 | Record entry at rd_addr |

## Verification
The bench aims at the corner cases below and what a wrong design would do in each.

- **Strobe phase.** An off-by-one in the strobe period would make the trigger phases step by 0 or 2 instead of 1. The per-trigger phase check catches this.
- **Restart in the middle of an acquisition.** A sequencer that kept its write address would store the new results at stale addresses. One that kept its counters would misplace the first strobe.
- **Converter latency.** Latencies from one clock up to twenty clocks are used. A design that closed the record at the 32nd trigger, rather than at the 32nd write, would drop the last result.
- **Valid outside an acquisition.** Junk valids are sent both before the first start and after done. A record that accepted them would show 0xEE on readback.

// File: rtl/etsg_pkg.sv
package etsg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_DONE = 2'd2
    } acq_state_e;
endpackage

// File: rtl/etsg_timebase.sv
module etsg_timebase #(
    parameter int STIM_PERIOD = 32,
    parameter int PULSE_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic stim_pulse,
    output logic stim_tc,
    output logic strobe
);
    localparam int STRB_PERIOD = STIM_PERIOD + 1;
    localparam int STIM_W      = $clog2(STIM_PERIOD);
    localparam int STRB_W      = $clog2(STRB_PERIOD);
    localparam logic [STIM_W-1:0] STIM_LAST = STIM_W'(STIM_PERIOD - 1);
    localparam logic [STIM_W-1:0] PULSE_END = STIM_W'(PULSE_W);
    localparam logic [STRB_W-1:0] STRB_LAST = STRB_W'(STRB_PERIOD - 1);

    logic [STIM_W-1:0] stim_cnt;
    logic [STRB_W-1:0] strb_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stim_cnt <= '0;
        end else if (run) begin
            stim_cnt <= (stim_cnt == STIM_LAST) ? '0 : stim_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            strb_cnt <= '0;
        end else if (run) begin
            strb_cnt <= (strb_cnt == STRB_LAST) ? '0 : strb_cnt + 1'b1;
        end
    end

    assign stim_pulse = run && (stim_cnt < PULSE_END);
    assign stim_tc    = run && (stim_cnt == STIM_LAST);
    assign strobe     = run && (strb_cnt == '0);
endmodule

// File: rtl/etsg_record.sv
module etsg_record #(
    parameter int RECORD = 32,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        run,
    input  logic                        valid,
    input  logic [DATA_W-1:0]           data,
    input  logic [$clog2(RECORD)-1:0]   rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        last_wr
);
    localparam int ADDR_W = $clog2(RECORD);
    localparam int CNT_W  = $clog2(RECORD + 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECORD - 1);

    logic [DATA_W-1:0] mem [RECORD];
    logic [CNT_W-1:0]  wr_cnt;
    logic              we;

    assign we = run && valid && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_cnt <= '0;
        end else if (we) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_cnt[ADDR_W-1:0]] <= data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign last_wr = we && (wr_cnt == REC_LAST);
endmodule

// File: rtl/etsg_ctrl.sv
module etsg_ctrl
    import etsg_pkg::*;
#(
    parameter int RECORD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic strobe,
    input  logic last_wr,
    output logic run,
    output logic trig,
    output logic done
);
    localparam int CNT_W = $clog2(RECORD + 1);
    localparam logic [CNT_W-1:0] REC_N = CNT_W'(RECORD);

    acq_state_e       state, nxt;
    logic [CNT_W-1:0] trig_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_ACQ;
            ST_ACQ: begin
                if (start)        nxt = ST_ACQ;
                else if (last_wr) nxt = ST_DONE;
            end
            ST_DONE: if (start) nxt = ST_ACQ;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            trig_cnt <= '0;
        end else if (trig) begin
            trig_cnt <= trig_cnt + 1'b1;
        end
    end

    always_comb begin
        run  = (state == ST_ACQ);
        done = (state == ST_DONE);
        trig = run && strobe && (trig_cnt < REC_N);
    end
endmodule

// File: rtl/equiv_strobe_gen.sv
module equiv_strobe_gen #(
    parameter int STIM_PERIOD = 32,
    parameter int PULSE_W     = 8,
    parameter int RECORD      = 32,
    parameter int DATA_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [DATA_W-1:0]         adc_data,
    input  logic                      adc_valid,
    input  logic [$clog2(RECORD)-1:0] rd_addr,
    output logic                      stim_pulse,
    output logic                      stim_tc,
    output logic                      strobe,
    output logic                      adc_trig,
    output logic                      done,
    output logic [DATA_W-1:0]         rd_data
);
    logic run;
    logic last_wr;

    etsg_ctrl #(.RECORD(RECORD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe),
        .last_wr(last_wr), .run(run), .trig(adc_trig), .done(done)
    );

    etsg_timebase #(.STIM_PERIOD(STIM_PERIOD), .PULSE_W(PULSE_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr(start), .run(run),
        .stim_pulse(stim_pulse), .stim_tc(stim_tc), .strobe(strobe)
    );

    etsg_record #(.RECORD(RECORD), .DATA_W(DATA_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .clr(start), .run(run),
        .valid(adc_valid), .data(adc_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .last_wr(last_wr)
    );
endmodule

// File: rtl/equiv_strobe_gen_chk.sv
module equiv_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic run,
    input logic stim_pulse,
    input logic stim_tc,
    input logic strobe,
    input logic adc_trig,
    input logic done
);
    AST_TRIG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> strobe && run);                                      // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);                                              // R4
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stim_tc |=> !stim_tc);                                            // R3
    AST_TC_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stim_tc |-> !stim_pulse);                                         // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(stim_pulse || stim_tc || strobe || adc_trig));         // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);                                         // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && run);                                          // R8
endmodule

bind equiv_strobe_gen equiv_strobe_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .stim_pulse(stim_pulse), .stim_tc(stim_tc), .strobe(strobe),
    .adc_trig(adc_trig), .done(done)
);

// File: tb/equiv_strobe_gen_bench.sv
module equiv_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] adc_data = 8'd0;
    logic       adc_valid = 1'b0;
    logic [4:0] rd_addr = 5'd0;
    logic       stim_pulse, stim_tc, strobe, adc_trig, done;
    logic [7:0] rd_data;

    equiv_strobe_gen u_equiv_strobe_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_data(adc_data),
        .adc_valid(adc_valid), .rd_addr(rd_addr), .stim_pulse(stim_pulse),
        .stim_tc(stim_tc), .strobe(strobe), .adc_trig(adc_trig),
        .done(done), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    bit  req_start = 0;
    bit  junk_en = 0;
    bit  lat_rand = 0;
    int  lat_fix = 1;
    int  pend = 0;
    int  pend_data = 0;
    int  trig_n = 0;
    int  exp_rec [32];

    // reference model state, from the requirements
    bit  mrun = 0, mdone = 0;
    int  mt = 0, mwr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_pulse(int t);  return (t % 32) < 8;  endfunction
    function automatic bit exp_tc(int t);     return (t % 32) == 31; endfunction
    function automatic bit exp_strobe(int t); return (t % 33) == 0;  endfunction
    function automatic bit exp_trig(int t);   return ((t % 33) == 0) && ((t / 33) < 32); endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mrun <= 0; mdone <= 0; mt <= 0; mwr <= 0;
        end else if (start) begin
            mrun <= 1; mdone <= 0; mt <= 0; mwr <= 0;
        end else if (mrun) begin
            mt <= mt + 1;
            if (adc_valid) begin
                mwr <= mwr + 1;
                if (mwr == 31) begin mrun <= 0; mdone <= 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(stim_pulse == (mrun && exp_pulse(mt)), "R2", stim_pulse, mrun && exp_pulse(mt));
            chk(stim_tc    == (mrun && exp_tc(mt)),    "R3", stim_tc,    mrun && exp_tc(mt));
            chk(strobe     == (mrun && exp_strobe(mt)),"R4", strobe,     mrun && exp_strobe(mt));
            chk(adc_trig   == (mrun && exp_trig(mt)),  "R5", adc_trig,   mrun && exp_trig(mt));
            chk(done == mdone, "R7", done, mdone);
            if (adc_trig && trig_n < 32) begin
                chk((mt % 32) == trig_n, "R5 phase", mt % 32, trig_n);
                pend_data = $urandom_range(0, 255);
                exp_rec[trig_n] = pend_data;
                pend = lat_rand ? $urandom_range(1, 20) : lat_fix;
                trig_n++;
            end
        end
        start = 1'b0;
        adc_valid = 1'b0;
        if (req_start) begin
            start = 1'b1; req_start = 0; pend = 0; trig_n = 0;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin adc_valid = 1'b1; adc_data = 8'(pend_data); end
        end else if (junk_en) begin
            adc_valid = 1'b1; adc_data = 8'hEE;
        end
    end

    task automatic launch();
        @(posedge clk); req_start = 1;
        @(negedge clk);
        @(negedge clk);
        chk(strobe && stim_pulse && !done, "R8 first strobe at t0", {strobe, stim_pulse, done}, 3'b110);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); rd_addr = 5'(i); #1;
            chk(rd_data == 8'(exp_rec[i]), req, rd_data, exp_rec[i]);
        end
    endtask

    task automatic junk(input int n);
        junk_en = 1;
        repeat (n) @(negedge clk);
        junk_en = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk({stim_pulse, stim_tc, strobe, adc_trig, done} == 5'b0, "R1 in reset",
            {stim_pulse, stim_tc, strobe, adc_trig, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({stim_pulse, stim_tc, strobe, adc_trig, done} == 5'b0, "R1 after reset",
            {stim_pulse, stim_tc, strobe, adc_trig, done}, 0);
        junk(6); // R9: valid while idle, no acquisition starts

        // R6: directed, one-clock converter latency
        lat_rand = 0; lat_fix = 1;
        launch(); wait_done();
        readback("R6 latency 1");
        junk(10);
        readback("R9 after done");

        // R6: random latencies
        lat_rand = 1;
        launch(); wait_done();
        readback("R6 random latency");

        // R8: restart in the middle of an acquisition
        launch();
        repeat ($urandom_range(100, 700)) @(negedge clk);
        launch(); wait_done();
        readback("R8 restart mid-run");

        // R7/R8: rearm from done with long latency
        lat_rand = 0; lat_fix = 20;
        launch(); wait_done();
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", done, 1);
        readback("R6 latency 20");
        summary();
    end
endmodule